// File: doc/BRIEF.md
# Ballot Tally Counter Bank

The block keeps a running vote count for each of eight candidates. Each candidate has its own detect line. When a line goes from low to high while the qualifying input `valid_i` is high, that candidate gains one vote. Only the rising edge counts, so a line that stays high adds a single vote.

All eight counters share one adder. A priority encoder turns the detected line into a candidate index. That index picks the candidate's tally through a multiplexer and feeds it to a single +1 stage. A one-hot decode of the same index then enables the write-back into that candidate's register, and no other register. A separate select input routes any one tally to the display output with no register delay. The surrounding system reads results by stepping the display select.

Top module: `ballot_tally`

## Requirements
- R1: While `rst_ni` is low, and directly after reset, every tally reads zero on `disp_tally_o`.
- R2: A rising edge on `ballot_i[k]`, sampled at a clock edge while `valid_i` is high, adds exactly one to tally k at that same clock edge.
- R3: A detect line held high over several clock edges adds only one vote. A line must return low and rise again before it can count again.
- R4: While `valid_i` is low, no tally changes. A rising edge seen while `valid_i` is low is dropped, even if `valid_i` goes high later while the line is still held.
- R5: A clock edge at which no detect line has a rising edge leaves all tallies unchanged.
- R6: When several lines rise at the same clock edge, only the lowest-numbered one (bit 0 has the highest priority) is counted. The others are dropped for that rise.
- R7: A tally at its all-ones value wraps to zero on its next vote.
- R8: `disp_tally_o` shows the tally of candidate `disp_sel_i` (binary index 0 to 7) in the same cycle, with no clock delay.
- R9: A vote writes only the chosen candidate's register. All other tallies keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; state changes on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, clears all tallies |
| valid_i | input | 1 | Qualifies detected edges as votes |
| ballot_i | input | 8 | One detect line per candidate, bit k = candidate k |
| disp_sel_i | input | 3 | Binary index of the tally to display |
| disp_tally_o | output | 32 | Tally of the selected candidate |

## Verification
The assertions assume that the detect lines and `valid_i` are synchronous to `clk_i` and are stable around the rising edge. They also assume the detect lines are low when reset is released, so that no edge is counted against state from before reset. The bench changes every input only on the falling clock edge and keeps the lines low around reset.

A second instance with 3-bit counters runs in parallel on the same stimulus. This makes the wrap at the all-ones value reachable within a short run.

// File: rtl/ballot_pkg.sv
package ballot_pkg;
  localparam int unsigned NUM_CAND = 8;
  localparam int unsigned CNT_W    = 32;
endpackage

// File: rtl/ballot_edge_detect.sv
module ballot_edge_detect #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] line_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= line_i;
  end

  assign rise_o = line_i & ~prev_q;

  // a line cannot show a rise on two consecutive edges
  a_r3_single_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/ballot_prio_enc.sv
module ballot_prio_enc #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |req_i;

  always_comb begin
    if (hit_o) begin
      a_r6_lowest_wins: assert (req_i[idx_o] &&
        ((req_i & ((N'(1) << idx_o) - N'(1))) == '0));
    end
  end
endmodule

// File: rtl/tally_mux.sv
module tally_mux #(
  parameter int unsigned N     = 8,
  parameter int unsigned W     = 32,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0][W-1:0] data_i,
  input  logic [IDX_W-1:0]    sel_i,
  output logic [W-1:0]        data_o
);
  assign data_o = data_i[sel_i];
endmodule

// File: rtl/tally_bank.sv
module tally_bank #(
  parameter int unsigned N     = 8,
  parameter int unsigned W     = 32,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic [N-1:0][W-1:0] tallies_o
);
  logic [N-1:0][W-1:0] tally_q;
  logic [N-1:0]        we;
  logic [W-1:0]        cur_val;
  logic [W-1:0]        nxt_val;

  // one shared adder serves every counter
  tally_mux #(.N(N), .W(W), .IDX_W(IDX_W)) u_inc_mux (
    .data_i (tally_q),
    .sel_i  (idx_i),
    .data_o (cur_val)
  );

  assign nxt_val = cur_val + W'(1);

  for (genvar g = 0; g < N; g++) begin : g_cnt
    assign we[g] = wr_i && (idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   tally_q[g] <= '0;
      else if (we[g]) tally_q[g] <= nxt_val;
    end
  end

  assign tallies_o = tally_q;

  a_r9_onehot_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we));

  a_r2_plus_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> tally_q[$past(idx_i)] == $past(cur_val) + W'(1));

  a_r7_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (cur_val == '1)) |=> tally_q[$past(idx_i)] == '0);
endmodule

// File: rtl/ballot_tally.sv
module ballot_tally
  import ballot_pkg::*;
#(
  parameter int unsigned N     = NUM_CAND,
  parameter int unsigned W     = CNT_W,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [N-1:0]     ballot_i,
  input  logic [IDX_W-1:0] disp_sel_i,
  output logic [W-1:0]     disp_tally_o
);
  logic [N-1:0]        rise;
  logic                hit;
  logic [IDX_W-1:0]    idx;
  logic                wr;
  logic [N-1:0][W-1:0] tallies;

  ballot_edge_detect #(.N(N)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (ballot_i),
    .rise_o (rise)
  );

  ballot_prio_enc #(.N(N), .IDX_W(IDX_W)) u_enc (
    .req_i (rise),
    .hit_o (hit),
    .idx_o (idx)
  );

  assign wr = valid_i && hit;

  tally_bank #(.N(N), .W(W), .IDX_W(IDX_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr),
    .idx_i     (idx),
    .tallies_o (tallies)
  );

  tally_mux #(.N(N), .W(W), .IDX_W(IDX_W)) u_disp_mux (
    .data_i (tallies),
    .sel_i  (disp_sel_i),
    .data_o (disp_tally_o)
  );

  a_r4_hold_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(tallies));

  a_r5_hold_no_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(tallies));
endmodule

// File: tb/ballot_tally_test.sv
module ballot_tally_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [7:0] ballot = '0;
  logic [2:0] sel = '0;
  logic [31:0] disp_big;
  logic [2:0]  disp_small;

  int unsigned cnt [8];
  logic [7:0]  mprev;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  ballot_tally uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .ballot_i(ballot),
    .disp_sel_i(sel), .disp_tally_o(disp_big)
  );

  ballot_tally #(.W(3)) uut_small (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .ballot_i(ballot),
    .disp_sel_i(sel), .disp_tally_o(disp_small)
  );

  task automatic sweep(input string tag);
    for (int s = 0; s < 8; s++) begin
      sel = 3'(s);
      #1;
      checks++;
      if (disp_big !== cnt[s]) begin
        errors++;
        $display("FAIL %s/R8 cand %0d: got %0d expected %0d", tag, s, disp_big, cnt[s]);
      end
      checks++;
      if (disp_small !== 3'(cnt[s])) begin
        errors++;
        $display("FAIL %s/R8 narrow cand %0d: got %0d expected %0d", tag, s, disp_small, 3'(cnt[s]));
      end
    end
  endtask

  task automatic drive(input logic [7:0] b, input logic v, input string tag);
    logic [7:0] rise;
    @(negedge clk);
    ballot = b;
    valid = v;
    @(posedge clk);
    rise = b & ~mprev;
    if (v && rise != 0) begin
      for (int k = 0; k < 8; k++) begin
        if (rise[k]) begin
          cnt[k]++;
          break;
        end
      end
    end
    mprev = b;
    #1;
    sweep(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    ballot = '0;
    valid = 1'b0;
    rst_n = 1'b0;
    for (int k = 0; k < 8; k++) cnt[k] = 0;
    mprev = '0;
    #1;
    sweep("R1 during reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    sweep("R1 after reset");
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung (all requirements)");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R2 single vote
    drive(8'h01, 1'b1, "R2");
    // R3 held line
    drive(8'h01, 1'b1, "R3");
    drive(8'h01, 1'b1, "R3");
    drive(8'h00, 1'b1, "R3");
    drive(8'h01, 1'b1, "R3 re-rise");
    drive(8'h00, 1'b1, "R3");
    // R4 rise while invalid is dropped
    drive(8'h02, 1'b0, "R4");
    drive(8'h02, 1'b1, "R4 late valid");
    drive(8'h00, 1'b1, "R4");
    // R5 no rise
    drive(8'h00, 1'b1, "R5");
    drive(8'h00, 1'b0, "R5");
    // R6 simultaneous rises
    drive(8'hA4, 1'b1, "R6");
    drive(8'hA4, 1'b1, "R6 hold");
    drive(8'h00, 1'b1, "R6");
    drive(8'hFF, 1'b1, "R6 all");
    drive(8'h00, 1'b1, "R6");
    drive(8'h80, 1'b1, "R6 lone high");
    drive(8'h00, 1'b1, "R6");
    // R9 other tallies untouched
    drive(8'h40, 1'b1, "R9");
    drive(8'h40, 1'b1, "R9");
    drive(8'h00, 1'b1, "R9");
    // R7 wrap on narrow instance
    for (int p = 0; p < 9; p++) begin
      drive(8'h20, 1'b1, "R7");
      drive(8'h00, 1'b1, "R7");
    end
    // R2 interleaved votes
    for (int p = 0; p < 8; p++) begin
      drive(8'(1 << p), 1'b1, "R2 sweep");
      drive(8'h00, 1'b0, "R2 sweep");
    end
    // R1 reset mid-run
    do_reset();
    drive(8'h08, 1'b1, "R2 after reset");
    drive(8'h00, 1'b1, "R2");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule